// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Sequencer

This block is the digital controller of a 14-bit successive-approximation converter. A host selects it with an active-low chip select and clocks an 8-bit command into a serial input. The first 1 seen on that input marks the start of the command. The command chooses the input range, the timing source and the operation. The operation is either a conversion or a calibration. During a conversion the block walks a trial code from MSB to LSB against an external comparator. It drives a strobe that tells the host when the conversion starts or ends, and it returns the result on a serial output.

All logic runs on one system clock `clk`. The serial clock `sclk` is sampled as an ordinary input, and its edges are found by comparing it with its value one cycle earlier. Each approximation or calibration step is taken on a serial-clock rising edge when the command selects external timing, or on a one-cycle `int_tick` pulse when it selects internal timing. The trial code goes out on `dac_code`. The comparator verdict comes back on `cmp_above`. A calibration engine outside this block reports completion on `cal_done`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `din` is sampled on serial-clock rising edges. A command is framed only by the first 1 seen while idle, which covers both after `cs_n` falls and after an operation ends. Leading 0s are ignored, and the 1 plus the next seven bits form the command, MSB first.
- R2: While `cs_n` is high, `dout_en` is 0, and serial-clock edges and `din` have no effect on framing, stepping or `dout`.
- R3: Command layout: bit 7 is the start bit. Bit 6 = 1 selects bipolar range and is held on `bipolar`. Bit 5 = 1 selects `int_tick` timing, 0 selects `sclk`. Bits 1:0 equal to 01 request a calibration, and every other value requests a conversion. Bits 4:2 are ignored.
- R4: In external timing, `strobe` is high for exactly one `clk` cycle, in the cycle after the command is accepted, and is low for the rest of the conversion.
- R5: In internal timing, `strobe` goes low when the conversion starts. It returns high two `clk` edges after the step edge that decides the LSB, and it stays high until the next conversion command.
- R6: A conversion takes 14 steps, MSB first. At each step the current trial bit is kept when `cmp_above` is 1 and cleared otherwise, and the next lower bit is set as the new trial. `dac_code` holds the final code afterwards.
- R7: In external timing, each serial-clock rise during a conversion performs one step. The bit decided at that step appears on `dout` at the following serial-clock fall.
- R8: After an internal-timing conversion, successive serial-clock falls put the result on `dout` MSB first, followed by 0s.
- R9: `dout` changes only on a serial-clock fall seen while `cs_n` is low, or on reset or shutdown.
- R10: `cal_active` is high from command acceptance until either `cal_done` is sampled high or CAL_STEPS timing steps have been taken, whichever comes first.
- R11: `rst_n` low at a `clk` edge returns the block to its power-on state: idle, with `strobe`, `dout`, `bipolar`, `cal_active` and `dac_code` all 0.
- R12: `shdn_n` low aborts any operation and holds the block in that same cleared idle state. After release, a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown, clears and idles the block |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| din | input | 1 | Serial command input |
| int_tick | input | 1 | Step enable for internal timing |
| cmp_above | input | 1 | Comparator: 1 when the trial level is not above the input |
| cal_done | input | 1 | Calibration complete from the calibration engine |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Output drive enable (0 means high impedance) |
| strobe | output | 1 | Conversion start/end strobe |
| bipolar | output | 1 | Registered range select |
| cal_active | output | 1 | Calibration in progress |
| dac_code | output | RES_BITS | Trial / final code |

## Verification
The bench aims at command framing after leading zeros and right after an operation ends. A design that framed on a fixed bit count would take a zero as the start bit and misread every field. It checks that a strobe which stays high too long in external timing, or rises one step early in internal timing, is caught cycle by cycle. It also checks the one-fall lag between a decided bit and `dout`; an off-by-one shift would shift the whole serial result. Calibration is ended both by `cal_done` and by the step count. Shutdown and reset are applied in the middle of conversions, and traffic is clocked with select high, to expose state that leaks across those events.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and command-byte field positions for the
// successive-approximation sequencer. Assumes an 8-bit command.
package adc_seq_pkg;
    localparam int CTRL_W  = 8;
    localparam int BIP_POS = 6;
    localparam int INT_POS = 5;
    localparam logic [1:0] OP_CAL = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_CAL  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       bipolar;
        logic       int_clk;
        logic [1:0] op;
    } ctrl_fields_t;
endpackage

// File: rtl/adc_sclk_edge.sv
// Serial-clock edge finder: compares sclk with its value one clk earlier.
// Assumes sclk is already synchronous to clk and much slower than it.
// Edges are gated off while chip select is high.
module adc_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Hold the previous serial-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = !cs_n &&  sclk && !sclk_q;
    assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/adc_ctrl_rx.sv
// Command receiver: while listening, waits for the first 1 on din at a
// serial-clock rise, then collects seven more bits. Issues a one-cycle
// valid pulse with the decoded fields. Assumes listen drops while busy.
module adc_ctrl_rx
    import adc_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         listen,
    input  logic         cs_n,
    input  logic         rise,
    input  logic         din,
    output logic         cmd_vld,
    output ctrl_fields_t cmd
);
    localparam int CNT_W = $clog2(CTRL_W);

    logic [CTRL_W-2:0] sh;
    logic [CNT_W-1:0]  cnt;

    // Frame and shift the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            cmd_vld <= 1'b0;
            cmd     <= '0;
        end else begin
            cmd_vld <= 1'b0;
            if (!listen || cs_n) begin
                cnt <= '0;
            end else if (rise) begin
                if (cnt == '0) begin
                    if (din) begin
                        cnt <= CNT_W'(1);
                        sh  <= {{(CTRL_W-2){1'b0}}, 1'b1};
                    end
                end else if (cnt == CNT_W'(CTRL_W-1)) begin
                    cmd_vld     <= sh[CTRL_W-2];
                    cmd.bipolar <= sh[BIP_POS-1];
                    cmd.int_clk <= sh[INT_POS-1];
                    cmd.op      <= {sh[0], din};
                    cnt         <= '0;
                end else begin
                    sh  <= {sh[CTRL_W-3:0], din};
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_sar_core.sv
// Approximation register: on start loads the MSB trial. On each step it
// keeps or clears the trial bit from the comparator and sets the next
// lower bit. After the LSB it pulses done one cycle later.
module adc_sar_core #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic         above,
    output logic [N-1:0] code,
    output logic         done
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] idx;
    logic          active;

    // Successive-approximation stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code   <= '0;
            idx    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                code   <= {1'b1, {(N-1){1'b0}}};
                idx    <= IW'(N-1);
                active <= 1'b1;
            end else if (step && active) begin
                code[idx] <= above;
                if (idx != '0) begin
                    code[idx - IW'(1)] <= 1'b1;
                    idx <= idx - IW'(1);
                end else begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top sequencer: accepts commands, runs a conversion or a calibration,
// drives the strobe and shifts results out on serial-clock falls.
// Assumes sclk is synchronous to clk; shutdown clears like reset.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS  = 14,
    parameter int CAL_STEPS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shdn_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic                int_tick,
    input  logic                cmp_above,
    input  logic                cal_done,
    output logic                dout,
    output logic                dout_en,
    output logic                strobe,
    output logic                bipolar,
    output logic                cal_active,
    output logic [RES_BITS-1:0] dac_code
);
    localparam int CAL_W = (CAL_STEPS > 1) ? $clog2(CAL_STEPS) : 1;

    logic          run_n, rise, fall, step, cmd_vld, is_cal;
    logic          sar_start, sar_step, sar_done;
    ctrl_fields_t  cmd;
    seq_state_t    state;
    logic          int_sel, pend, pend_bit;
    logic [RES_BITS-1:0] out_sh, code;
    logic [CAL_W-1:0]    cal_cnt;

    assign run_n     = rst_n & shdn_n;
    assign step      = int_sel ? int_tick : rise;
    assign is_cal    = (cmd.op == OP_CAL);
    assign sar_start = cmd_vld && (state == ST_IDLE) && !is_cal;
    assign sar_step  = (state == ST_CONV) && step;

    adc_sclk_edge u_edge (
        .clk(clk), .rst_n(run_n), .sclk(sclk), .cs_n(cs_n),
        .rise(rise), .fall(fall)
    );

    adc_ctrl_rx u_rx (
        .clk(clk), .rst_n(run_n), .listen(state == ST_IDLE), .cs_n(cs_n),
        .rise(rise), .din(din), .cmd_vld(cmd_vld), .cmd(cmd)
    );

    adc_sar_core #(.N(RES_BITS)) u_sar (
        .clk(clk), .rst_n(run_n), .start(sar_start), .step(sar_step),
        .above(cmp_above), .code(code), .done(sar_done)
    );

    // Sequencer state, strobe and serial output path.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            state    <= ST_IDLE;
            int_sel  <= 1'b0;
            bipolar  <= 1'b0;
            strobe   <= 1'b0;
            pend     <= 1'b0;
            pend_bit <= 1'b0;
            out_sh   <= '0;
            dout     <= 1'b0;
            cal_cnt  <= '0;
        end else begin
            if (fall) begin
                if (pend) begin
                    dout <= pend_bit;
                    pend <= 1'b0;
                end else begin
                    dout   <= out_sh[RES_BITS-1];
                    out_sh <= {out_sh[RES_BITS-2:0], 1'b0};
                end
            end
            unique case (state)
                ST_IDLE: begin
                    if (cmd_vld) begin
                        bipolar <= cmd.bipolar;
                        int_sel <= cmd.int_clk;
                        pend    <= 1'b0;
                        out_sh  <= '0;
                        if (is_cal) begin
                            state   <= ST_CAL;
                            cal_cnt <= '0;
                        end else begin
                            state  <= ST_CONV;
                            strobe <= !cmd.int_clk;
                        end
                    end
                end
                ST_CONV: begin
                    if (!int_sel) strobe <= 1'b0;
                    if (sar_step && !int_sel) begin
                        pend     <= 1'b1;
                        pend_bit <= cmp_above;
                    end
                    if (sar_done) begin
                        state <= ST_IDLE;
                        if (int_sel) begin
                            strobe <= 1'b1;
                            out_sh <= code;
                        end
                    end
                end
                ST_CAL: begin
                    if (cal_done || (step && cal_cnt == CAL_W'(CAL_STEPS-1)))
                        state <= ST_IDLE;
                    else if (step)
                        cal_cnt <= cal_cnt + CAL_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign dout_en    = !cs_n;
    assign cal_active = (state == ST_CAL);
    assign dac_code   = code;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Checker: temporal properties of the sequencer ports, attached by bind.
// Assumes synchronous active-low reset.
module adc_seq_ctrl_chk #(
    parameter int N = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shdn_n,
    input logic         cs_n,
    input logic         sclk,
    input logic         dout,
    input logic         dout_en,
    input logic         strobe,
    input logic         cal_active,
    input logic         cal_done,
    input logic         int_sel,
    input logic [N-1:0] dac_code
);
    logic [1:0] armed;

    // Count settled cycles since reset so that $past has valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 2'd0;
        else if (armed != 2'd3)  armed <= armed + 2'd1;
    end

    // R2
    out_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_en);

    // R9
    dout_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed == 2'd3 && dout != $past(dout)) |->
        ((!$past(sclk) && $past(sclk, 2) && !$past(cs_n)) || !$past(shdn_n)));

    // R4
    ext_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !int_sel) |=> !strobe);

    // R10
    cal_done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_active && cal_done) |=> !cal_active);

    // R12
    shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!strobe && !cal_active && dac_code == '0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.N(RES_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
    .dout(dout), .dout_en(dout_en), .strobe(strobe), .cal_active(cal_active),
    .cal_done(cal_done), .int_sel(int_sel), .dac_code(dac_code)
);

// File: tb/adc_seq_ctrl_test.sv
// Bench: behavioural cycle model compared on every clock, plus directed
// checks of conversions, calibrations, framing, select, reset, shutdown.
module adc_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0, shdn_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic int_tick = 1'b0, cal_done = 1'b0, cmp_above;
    logic dout, dout_en, strobe, bipolar, cal_active;
    logic [13:0] dac_code;
    logic [13:0] vin = '0;
    int checks = 0, fails = 0, stb_cnt = 0;
    bit cmp_en = 0, done_flag = 0;

    always #5 clk = ~clk;

    assign cmp_above = (dac_code <= vin);

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
        .din(din), .int_tick(int_tick), .cmp_above(cmp_above),
        .cal_done(cal_done), .dout(dout), .dout_en(dout_en), .strobe(strobe),
        .bipolar(bipolar), .cal_active(cal_active), .dac_code(dac_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_state = 0, m_bc = 0, m_byte = 0, m_idx = 0, m_calc = 0;
    bit  m_sq, m_vld, m_done, m_int, m_bip, m_stb, m_pend, m_pbit, m_dout, m_active;
    logic [13:0] m_code = '0, m_out = '0;

    always @(posedge clk) begin : model
        bit r, f, st, v, d;
        if (!rst_n || !shdn_n) begin
            m_state = 0; m_bc = 0; m_byte = 0; m_idx = 0; m_calc = 0;
            m_sq = 0; m_vld = 0; m_done = 0; m_int = 0; m_bip = 0; m_stb = 0;
            m_pend = 0; m_pbit = 0; m_dout = 0; m_active = 0;
            m_code = '0; m_out = '0;
        end else begin
            r = !cs_n && sclk && !m_sq;
            f = !cs_n && !sclk && m_sq;
            m_sq = sclk;
            st = m_int ? int_tick : r;
            v = m_vld; m_vld = 0;
            d = m_done; m_done = 0;
            if (f) begin
                if (m_pend) begin m_dout = m_pbit; m_pend = 0; end
                else begin m_dout = m_out[13]; m_out = m_out << 1; end
            end
            if (m_state != 0 || cs_n) m_bc = 0;
            else if (r) begin
                if (m_bc == 0) begin
                    if (din) begin m_bc = 1; m_byte = 1; end
                end else begin
                    m_byte = m_byte * 2 + din;
                    m_bc++;
                    if (m_bc == 8) begin m_vld = 1; m_bc = 0; end
                end
            end
            case (m_state)
                0: if (v) begin
                    m_bip = m_byte[6]; m_int = m_byte[5]; m_pend = 0; m_out = '0;
                    if (m_byte % 4 == 1) begin m_state = 2; m_calc = 0; end
                    else begin
                        m_state = 1; m_stb = !m_byte[5];
                        m_code = 14'h2000; m_idx = 13; m_active = 1;
                    end
                end
                1: begin
                    if (!m_int) m_stb = 0;
                    if (st) begin
                        if (!m_int) begin m_pend = 1; m_pbit = cmp_above; end
                        if (m_active) begin
                            m_code[m_idx] = cmp_above;
                            if (m_idx > 0) begin m_idx--; m_code[m_idx] = 1'b1; end
                            else begin m_active = 0; m_done = 1; end
                        end
                    end
                    if (d) begin
                        m_state = 0;
                        if (m_int) begin m_stb = 1; m_out = m_code; end
                    end
                end
                default: begin
                    if (cal_done || (st && m_calc == 63)) m_state = 0;
                    else if (st) m_calc++;
                end
            endcase
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && strobe) stb_cnt++;
        if (cmp_en && !done_flag) begin
            chk("R9 dout", {31'd0, dout}, {31'd0, m_dout});
            chk("R2 dout_en", {31'd0, dout_en}, {31'd0, !cs_n});
            chk("R4 strobe", {31'd0, strobe}, {31'd0, m_stb});
            chk("R3 bipolar", {31'd0, bipolar}, {31'd0, m_bip});
            chk("R10 cal_active", {31'd0, cal_active}, {31'd0, m_state == 2});
            chk("R6 dac_code", {18'd0, dac_code}, {18'd0, m_code});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic clk_bit(input logic b);
        @(negedge clk) din = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    endtask

    task automatic tick();
        @(negedge clk) int_tick = 1'b1;
        @(negedge clk) int_tick = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 strobe", {31'd0, strobe}, 0);
        chk("R11 dac_code", {18'd0, dac_code}, 0);
        chk("R11 cal_active", {31'd0, cal_active}, 0);
        chk("R11 dout", {31'd0, dout}, 0);

        cs_n = 1'b0;
        // R1 leading zeros, R4/R7 external conversion, bipolar, op 00
        vin = 14'h2A5C; stb_cnt = 0;
        repeat (3) clk_bit(1'b0);
        send_byte(8'hC0);
        for (int k = 13; k >= 0; k--) begin
            clk_bit(1'b0);
            chk("R7 ext bit", {31'd0, dout}, {31'd0, vin[k]});
        end
        repeat (4) @(negedge clk);
        chk("R4 pulse count", stb_cnt, 1);
        chk("R6 ext result", {18'd0, dac_code}, {18'd0, vin});
        chk("R3 bipolar set", {31'd0, bipolar}, 1);

        // R5/R8 internal conversion, op 11, framed right after completion (R1)
        vin = 14'h1337;
        send_byte(8'hA3);
        repeat (2) @(negedge clk);
        chk("R5 strobe low", {31'd0, strobe}, 0);
        chk("R3 unipolar", {31'd0, bipolar}, 0);
        repeat (13) tick();
        chk("R5 still low", {31'd0, strobe}, 0);
        tick();
        repeat (3) @(negedge clk);
        chk("R5 strobe high", {31'd0, strobe}, 1);
        chk("R6 int result", {18'd0, dac_code}, {18'd0, vin});
        for (int k = 13; k >= 0; k--) begin
            clk_bit(1'b0);
            chk("R8 readout", {31'd0, dout}, {31'd0, vin[k]});
        end
        clk_bit(1'b0);
        chk("R8 zero fill", {31'd0, dout}, 0);

        // R3 op 10 is a conversion
        vin = 14'h3FFF;
        send_byte(8'hC2);
        repeat (2) @(negedge clk);
        chk("R3 op10 no cal", {31'd0, cal_active}, 0);
        repeat (14) clk_bit(1'b0);
        repeat (3) @(negedge clk);
        chk("R6 full scale", {18'd0, dac_code}, 14'h3FFF);

        // R10 calibration ended by cal_done
        send_byte(8'h81);
        repeat (2) @(negedge clk);
        chk("R10 cal on", {31'd0, cal_active}, 1);
        repeat (5) clk_bit(1'b0);
        chk("R10 cal holds", {31'd0, cal_active}, 1);
        @(negedge clk) cal_done = 1'b1;
        @(negedge clk) cal_done = 1'b0;
        chk("R10 cal_done ends", {31'd0, cal_active}, 0);

        // R10 calibration ended by step count
        send_byte(8'hA1);
        repeat (2) @(negedge clk);
        repeat (63) tick();
        chk("R10 before count", {31'd0, cal_active}, 1);
        tick();
        chk("R10 count ends", {31'd0, cal_active}, 0);

        // R2 select high: traffic ignored
        cs_n = 1'b1;
        send_byte(8'h81);
        repeat (3) @(negedge clk);
        chk("R2 hiz", {31'd0, dout_en}, 0);
        chk("R2 ignored", {31'd0, cal_active}, 0);
        cs_n = 1'b0;
        send_byte(8'h81);
        repeat (2) @(negedge clk);
        chk("R1 after select", {31'd0, cal_active}, 1);
        @(negedge clk) cal_done = 1'b1;
        @(negedge clk) cal_done = 1'b0;

        // R12 shutdown mid conversion
        vin = 14'h0A0A;
        send_byte(8'hC0);
        repeat (3) clk_bit(1'b0);
        shdn_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 dac_code", {18'd0, dac_code}, 0);
        chk("R12 bipolar", {31'd0, bipolar}, 0);
        chk("R12 strobe", {31'd0, strobe}, 0);
        shdn_n = 1'b1;
        send_byte(8'h81);
        repeat (2) @(negedge clk);
        chk("R12 recovers", {31'd0, cal_active}, 1);
        @(negedge clk) cal_done = 1'b1;
        @(negedge clk) cal_done = 1'b0;

        // R11 reset mid internal conversion
        send_byte(8'hE3);
        repeat (5) tick();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 mid dac_code", {18'd0, dac_code}, 0);
        chk("R11 mid bipolar", {31'd0, bipolar}, 0);
        chk("R11 mid strobe", {31'd0, strobe}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule